// File: doc/BRIEF.md
# Two-Key Watchdog Service Unit

This block is a software watchdog. A countdown counter, stepped by a fixed clock prescaler, raises a one-cycle expiry pulse whenever it runs out. The chip uses that pulse to request a reset or an interrupt. Firmware keeps the watchdog from expiring by writing two 16-bit keys, in order, to a service register on a simple register bus. A single write, or the keys in the wrong order, does not reload the counter.

The bus has an address, write data, a write strobe and combinational read data. Besides the write-only service register, the bus reaches a control register that holds the enable bit, a period register that sets the reload value, and a read-only view of the live count. Keys can be written at any time and have no open or closed window.

Top module: `wdog_service_unit`

## Requirements
- R1: A service-register write of 0x556C followed by a service-register write of 0xAA39 reloads the counter with the period register value on the clock edge that takes the second write. Bus cycles that do not write the service register may come between the two writes.
- R2: A read at offset 0x10014 returns the current counter value. A read at an unmapped offset returns zero.
- R3: The service register is at offset 0x1000E and accepts the key pair at any time, including while the watchdog is disabled.
- R4: A read at the service register offset always returns 0x0000.
- R5: A write of 0xAA39 that does not directly follow an arming 0x556C leaves the counter and the expiry output unaffected.
- R6: Any service-register write other than 0x556C disarms the detector, so a 0xAA39 that follows it does not reload.
- R7: Two consecutive 0x556C writes leave the detector armed, and a following 0xAA39 reloads.
- R8: While enabled, the counter steps once every PRESCALE clocks. A step taken at count zero reloads the period and drives wdt_expire high for exactly one cycle. After a reload, that pulse is due PRESCALE*(period+1) clock edges later.
- R9: Bit 0 of the control register at offset 0x10010 is the enable. While it is 0, the counter holds its value and wdt_expire stays low. A read returns the bit in position 0 and zeros above it.
- R10: The period register at offset 0x10012 is read/write. A new value takes effect at the next reload, whether that reload comes from a service or from an expiry.
- R11: After reset the detector is disarmed, the enable bit is 1, and both the period and the counter hold PERIOD_RST (40 by default).
- R12: A service reload also restarts the prescaler, so the first step after it comes a full PRESCALE clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| wdt_expire | output | 1 | One-cycle expiry pulse |

## Verification
Read data is combinational, so a read is checked in the same cycle its address is driven. A write is visible through a read in the cycle after the edge that takes it. The expiry pulse is registered: it appears one cycle after the prescaler step that finds the count at zero, which puts it PRESCALE*(period+1) edges after a service reload. Inputs change shortly after each rising edge, and the reference model advances on that edge from the values it samples. Outputs are compared on the falling edge, so every check falls in the cycle where its result is due.

// File: rtl/wdsvc_pkg.sv
package wdsvc_pkg;
    localparam int DATA_W = 16;
    typedef logic [DATA_W-1:0] word_t;

    localparam word_t KEY_ARM  = 16'h556C;
    localparam word_t KEY_FIRE = 16'hAA39;

    localparam int EN_BIT = 0;
endpackage

// File: rtl/wdsvc_keyseq.sv
module wdsvc_keyseq
    import wdsvc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  svc_wr,
    input  word_t svc_data,
    output logic  armed,
    output logic  fire
);
    typedef struct packed {
        logic armed;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (svc_wr) begin
            seq_d.armed = (svc_data == KEY_ARM);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign armed = seq_q.armed;
    assign fire  = svc_wr && seq_q.armed && (svc_data == KEY_FIRE);
endmodule

// File: rtl/wdsvc_prescaler.sv
module wdsvc_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (restart) begin
            pre_d = '0;
        end else if (run) begin
            pre_d = (pre_q == LAST) ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_d;
    end

    assign tick = run && (pre_q == LAST);
endmodule

// File: rtl/wdsvc_counter.sv
module wdsvc_counter #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = W'(40)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         reload,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         expire
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         expire;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.expire = 1'b0;
        if (reload) begin
            st_d.cnt = period;
        end else if (step) begin
            if (st_q.cnt == '0) begin
                st_d.cnt    = period;
                st_d.expire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{cnt: RST_VAL, expire: 1'b0};
        else     st_q <= st_d;
    end

    assign count  = st_q.cnt;
    assign expire = st_q.expire;
endmodule

// File: rtl/wdog_service_unit.sv
module wdog_service_unit
    import wdsvc_pkg::*;
#(
    parameter int               ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] SVC_OFS   = 20'h1000E,
    parameter logic [ADDR_W-1:0] CTL_OFS   = 20'h10010,
    parameter logic [ADDR_W-1:0] PER_OFS   = 20'h10012,
    parameter logic [ADDR_W-1:0] CNT_OFS   = 20'h10014,
    parameter int               PRESCALE   = 4,
    parameter int               PERIOD_RST = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_wr,
    output logic [15:0]       bus_rdata,
    output logic              wdt_expire
);
    typedef struct packed {
        logic  en;
        word_t period;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    logic  wr_svc, wr_ctl, wr_per;
    logic  armed, svc_reload, step;
    word_t cnt_val;

    assign wr_svc = bus_wr && (bus_addr == SVC_OFS);
    assign wr_ctl = bus_wr && (bus_addr == CTL_OFS);
    assign wr_per = bus_wr && (bus_addr == PER_OFS);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctl) ctl_d.en     = bus_wdata[EN_BIT];
        if (wr_per) ctl_d.period = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{en: 1'b1, period: word_t'(PERIOD_RST)};
        else     ctl_q <= ctl_d;
    end

    wdsvc_keyseq u_keyseq (
        .clk      (clk),
        .rst      (rst),
        .svc_wr   (wr_svc),
        .svc_data (bus_wdata),
        .armed    (armed),
        .fire     (svc_reload)
    );

    wdsvc_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (ctl_q.en),
        .restart (svc_reload),
        .tick    (step)
    );

    wdsvc_counter #(.W(DATA_W), .RST_VAL(word_t'(PERIOD_RST))) u_count (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .reload (svc_reload),
        .period (ctl_q.period),
        .count  (cnt_val),
        .expire (wdt_expire)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTL_OFS)      bus_rdata[EN_BIT] = ctl_q.en;
        else if (bus_addr == PER_OFS) bus_rdata = ctl_q.period;
        else if (bus_addr == CNT_OFS) bus_rdata = cnt_val;
    end
endmodule

// File: rtl/wdsvc_checker.sv
module wdsvc_checker
    import wdsvc_pkg::*;
#(
    parameter int               ADDR_W  = 20,
    parameter logic [ADDR_W-1:0] SVC_OFS = 20'h1000E
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              bus_wr,
    input logic [15:0]       bus_rdata,
    input logic              wdt_expire,
    input logic              en,
    input logic              armed,
    input logic              reload,
    input logic [15:0]       period,
    input logic [15:0]       count
);
    logic svc_wr;
    assign svc_wr = bus_wr && (bus_addr == SVC_OFS);

    assert_svc_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == SVC_OFS) |-> (bus_rdata == 16'h0000));

    assert_reload_loads_period_R1: assert property (@(posedge clk) disable iff (rst)
        reload |=> (count == $past(period)));

    assert_other_key_disarms_R6: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && bus_wdata != KEY_ARM) |=> !armed);

    assert_arm_key_arms_R7: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && bus_wdata == KEY_ARM) |=> armed);

    assert_expire_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        wdt_expire |=> !wdt_expire);

    assert_frozen_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        (!en && !reload) |=> $stable(count));

    assert_no_expire_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> !wdt_expire);
endmodule

bind wdog_service_unit wdsvc_checker #(.ADDR_W(ADDR_W), .SVC_OFS(SVC_OFS)) u_wdsvc_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .wdt_expire (wdt_expire),
    .en         (ctl_q.en),
    .armed      (armed),
    .reload     (svc_reload),
    .period     (ctl_q.period),
    .count      (cnt_val)
);

// File: tb/test_wdog_service_unit.sv
module test_wdog_service_unit;
    localparam logic [19:0] A_SVC = 20'h1000E;
    localparam logic [19:0] A_CTL = 20'h10010;
    localparam logic [19:0] A_PER = 20'h10012;
    localparam logic [19:0] A_CNT = 20'h10014;
    localparam logic [19:0] A_NONE = 20'h00040;
    localparam int DIV = 4;
    localparam int PRST = 40;
    localparam logic [15:0] K1 = 16'h556C;
    localparam logic [15:0] K2 = 16'hAA39;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        wr = 1'b0;
    logic [15:0] rdata;
    logic        expire;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    wdog_service_unit i_wdog_service_unit (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_wr     (wr),
        .bus_rdata  (rdata),
        .wdt_expire (expire)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit m_arm, m_en, m_to;
    int m_cnt, m_pre, m_per;

    always @(posedge clk) begin
        if (rst) begin
            m_arm = 0; m_en = 1; m_to = 0;
            m_cnt = PRST; m_pre = 0; m_per = PRST;
        end else begin
            bit svc, rl;
            svc = wr && addr == A_SVC;
            rl  = svc && m_arm && wdata == K2;
            m_to = 0;
            if (rl) begin
                m_cnt = m_per; m_pre = 0;
            end else if (m_en) begin
                if (m_pre == DIV - 1) begin
                    m_pre = 0;
                    if (m_cnt == 0) begin m_cnt = m_per; m_to = 1; end
                    else m_cnt = m_cnt - 1;
                end else m_pre = m_pre + 1;
            end
            if (svc) m_arm = (wdata == K1);
            if (wr && addr == A_CTL) m_en = wdata[0];
            if (wr && addr == A_PER) m_per = int'(wdata);
        end
    end

    function automatic int exp_rd(logic [19:0] a);
        if (a == A_CTL) return int'(m_en);
        if (a == A_PER) return m_per;
        if (a == A_CNT) return m_cnt;
        return 0;
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R8 expire vs model", int'(expire), int'(m_to));
            if (addr == A_SVC) chk("R4 service read", int'(rdata), 0);
            else chk("R2 read vs model", int'(rdata), exp_rd(addr));
        end
    end

    task automatic drive(logic [19:0] a, logic [15:0] d, logic w);
        @(posedge clk);
        #2;
        addr = a; wdata = d; wr = w;
    endtask

    task automatic rd(logic [19:0] a, output int v);
        drive(a, '0, 1'b0);
        @(negedge clk);
        v = int'(rdata);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, v2, n, pulses;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R11 reset state
        rd(A_CNT, v); chk("R11 count after reset", v, PRST);
        rd(A_CTL, v); chk("R11 enable after reset", v, 1);
        rd(A_PER, v); chk("R11 period after reset", v, PRST);
        rd(A_NONE, v); chk("R2 unmapped read", v, 0);

        repeat (20) drive(A_CNT, '0, 1'b0);
        rd(A_CNT, v); chk("R8 counter has stepped", int'(v < PRST), 1);

        // R1 basic service, with an unrelated write in between
        drive(A_SVC, K1, 1'b1);
        drive(A_NONE, 16'h1234, 1'b1);
        drive(A_SVC, K2, 1'b1);
        rd(A_CNT, v); chk("R1 reload after key pair", v, PRST);
        rd(A_SVC, v); chk("R4 service read zero", v, 0);

        // R12 prescaler restarted: first step 4 edges after reload
        drive(A_SVC, K1, 1'b1);
        drive(A_SVC, K2, 1'b1);
        rd(A_CNT, v);
        repeat (3) drive(A_CNT, '0, 1'b0);
        @(negedge clk); chk("R12 no step before PRESCALE", int'(rdata), PRST);
        drive(A_CNT, '0, 1'b0);
        @(negedge clk); chk("R12 step at PRESCALE", int'(rdata), PRST - 1);

        // R5 second key alone
        repeat (12) drive(A_CNT, '0, 1'b0);
        rd(A_CNT, v);
        drive(A_SVC, K2, 1'b1);
        rd(A_CNT, v2); chk("R5 lone second key ignored", int'(v2 <= v), 1);

        // R6 wrong value between keys
        drive(A_SVC, K1, 1'b1);
        drive(A_SVC, 16'h0001, 1'b1);
        drive(A_SVC, K2, 1'b1);
        rd(A_CNT, v); chk("R6 broken sequence no reload", int'(v < PRST), 1);

        // R7 first key twice
        drive(A_SVC, K1, 1'b1);
        drive(A_SVC, K1, 1'b1);
        drive(A_SVC, K2, 1'b1);
        rd(A_CNT, v); chk("R7 double first key then reload", v, PRST);

        // R8 timeout timing from a reload
        drive(A_SVC, K1, 1'b1);
        drive(A_SVC, K2, 1'b1);
        drive(A_CNT, '0, 1'b0);
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (expire) break;
        end
        chk("R8 expire delay", n, DIV * (PRST + 1));
        @(negedge clk); chk("R8 pulse one cycle", int'(expire), 0);
        chk("R8 count reloaded by expiry", int'(rdata), PRST);

        // R10 new period
        drive(A_PER, 16'd10, 1'b1);
        rd(A_PER, v); chk("R10 period readback", v, 10);
        drive(A_SVC, K1, 1'b1);
        drive(A_SVC, K2, 1'b1);
        rd(A_CNT, v); chk("R10 reload uses new period", v, 10);
        pulses = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (expire) pulses++;
        end
        chk("R10 expiries with short period", int'(pulses >= 4), 1);

        // R9 disable freezes
        drive(A_CTL, 16'h0000, 1'b1);
        rd(A_CTL, v); chk("R9 enable cleared", v, 0);
        rd(A_CNT, v);
        pulses = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (expire) pulses++;
        end
        chk("R9 no expiry while off", pulses, 0);
        rd(A_CNT, v2); chk("R9 count frozen", v2, v);

        // R3 service while disabled
        drive(A_PER, 16'd25, 1'b1);
        drive(A_SVC, K1, 1'b1);
        drive(A_SVC, K2, 1'b1);
        rd(A_CNT, v); chk("R3 service while disabled", v, 25);
        drive(A_CTL, 16'h0001, 1'b1);
        rd(A_CTL, v); chk("R9 enable set again", v, 1);
        repeat (150) drive(A_CNT, '0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule